// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Bank

This block holds the software-visible state of a vectored interrupt controller with a parameterised number of level-sensitive request lines (32 by default). A simple word-addressed register bus reaches one configuration word per line, an enable mask, a software-request mask, a controller configuration word and a vector table base. Each mask can be written directly, or changed through a set-bits alias and a clear-bits alias, so that bits can change without a read-modify-write.

The block samples the request lines into a raw status register. It forms the pending mask as the merge of hardware and software requests, gated by the enable mask. It exports the configuration words, the enable and pending masks, the controller configuration and the vector base to a separate priority resolver. The resolver returns a status word and a vector address. The block captures both and makes them readable on the bus.

Accesses are full words only. The bus address is a word index (byte offset divided by four).

Top module: `irq_csr_bank`

## Requirements
- R1: Indices 0 to NUM_LINES-1 are per-line configuration words. A write stores the full word. A read returns it. Word i appears on `cfg_words[i*32 +: 32]` from the cycle after the write.
- R2: The enable mask is at index 32. Writing index 32 replaces it. Writing index 33 ORs the written bits into it. Writing index 34 clears every bit set in the written value. The mask changes only on these writes.
- R3: The software-request mask has the same three forms at indices 37 (replace), 38 (set) and 39 (clear).
- R4: Index 35 and the `pend_mask` output give (raw status OR software mask) AND enable mask.
- R5: Index 36 returns raw status. Bit i is the level of `irq_in[i]` sampled at the previous clock edge, with no latching, so it drops when the line drops.
- R6: Index 40 is the controller configuration word and index 42 is the vector table base. Both are read/write and are driven on `ctl_cfg` and `vec_base`.
- R7: Index 41 returns `res_status` and index 43 returns `res_vec_addr`, each captured by a register on every clock.
- R8: Reads of the alias indices 33, 34, 38 and 39, and of any index above 43, return zero.
- R9: A write to a read-only index (35, 36, 41, 43) or to an index above 43 changes no state and raises `bad_write` for one cycle. A write to a writable index leaves `bad_write` low.
- R10: A synchronous reset clears every configuration word, both masks, raw status, controller configuration, vector base, captured status, captured vector address, `rdata` and `bad_write`.
- R11: `rdata` is registered. It carries the selected word in the cycle after `rd_en` and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word index of the access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid one cycle after rd_en |
| bad_write | output | 1 | One-cycle flag for a write to a read-only or unmapped index |
| irq_in | input | NUM_LINES | Level-sensitive request lines |
| res_status | input | DW | Status word from the resolver |
| res_vec_addr | input | DW | Vector address from the resolver |
| cfg_words | output | NUM_LINES*DW | All configuration words, word i at bits i*DW |
| en_mask | output | NUM_LINES | Enable mask |
| pend_mask | output | NUM_LINES | Pending mask |
| ctl_cfg | output | DW | Controller configuration word |
| vec_base | output | DW | Vector table base |

## Verification
A wrong mask bit shows on `en_mask` or `pend_mask` one cycle after the write that caused it, and the resolver would act on it right away. A wrong configuration word shows only on its slice of `cfg_words` or on a readback, so the bench checks each write both ways. A decode slip that lets a read-only or unmapped write through shows at the next read of a neighbouring register, and as a missing `bad_write` pulse in the cycle after the write. Raw status is checked after the line drops, which catches any accidental latching within two cycles.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;
  // Offsets of the control registers above the per-line configuration words
  localparam int unsigned OFS_EN     = 0;
  localparam int unsigned OFS_EN_SET = 1;
  localparam int unsigned OFS_EN_CLR = 2;
  localparam int unsigned OFS_PEND   = 3;
  localparam int unsigned OFS_RAW    = 4;
  localparam int unsigned OFS_SW     = 5;
  localparam int unsigned OFS_SW_SET = 6;
  localparam int unsigned OFS_SW_CLR = 7;
  localparam int unsigned OFS_CTL    = 8;
  localparam int unsigned OFS_STAT   = 9;
  localparam int unsigned OFS_BASE   = 10;
  localparam int unsigned OFS_VADDR  = 11;
  localparam int unsigned NUM_OFS    = 12;

  typedef struct packed {
    logic cfg;
    logic en_wr;
    logic en_set;
    logic en_clr;
    logic sw_wr;
    logic sw_set;
    logic sw_clr;
    logic ctl_wr;
    logic base_wr;
    logic bad;
  } wr_strb_t;
endpackage

// File: rtl/irq_csr_dec.sv
module irq_csr_dec
  import irq_csr_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output wr_strb_t          strb
);
  localparam int unsigned BASE = NUM_LINES;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(BASE + ofs);
  endfunction

  always_comb begin
    strb         = '0;
    strb.cfg     = wr_en && (addr < ADDR_W'(NUM_LINES));
    strb.en_wr   = wr_en && hit(addr, OFS_EN);
    strb.en_set  = wr_en && hit(addr, OFS_EN_SET);
    strb.en_clr  = wr_en && hit(addr, OFS_EN_CLR);
    strb.sw_wr   = wr_en && hit(addr, OFS_SW);
    strb.sw_set  = wr_en && hit(addr, OFS_SW_SET);
    strb.sw_clr  = wr_en && hit(addr, OFS_SW_CLR);
    strb.ctl_wr  = wr_en && hit(addr, OFS_CTL);
    strb.base_wr = wr_en && hit(addr, OFS_BASE);
    strb.bad     = wr_en && !(strb.cfg || strb.en_wr || strb.en_set || strb.en_clr ||
                              strb.sw_wr || strb.sw_set || strb.sw_clr ||
                              strb.ctl_wr || strb.base_wr);
  end
endmodule

// File: rtl/irq_csr_mask.sv
module irq_csr_mask #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic         set,
  input  logic         clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (wr)  q <= wdata;
    else if (set) q <= q | wdata;
    else if (clr) q <= q & ~wdata;
  end
endmodule

// File: rtl/irq_csr_cfg.sv
module irq_csr_cfg #(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned DW        = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [LW-1:0]           widx,
  input  logic [DW-1:0]           wdata,
  input  logic [LW-1:0]           ridx,
  output logic [DW-1:0]           rword,
  output logic [NUM_LINES*DW-1:0] flat
);
  localparam int unsigned LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [DW-1:0] words [NUM_LINES];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                         words[i] <= '0;
      else if (we && widx == LW'(i))   words[i] <= wdata;
    end
    assign flat[i*DW +: DW] = words[i];
  end

  assign rword = words[ridx];
endmodule

// File: rtl/irq_csr_bank.sv
module irq_csr_bank
  import irq_csr_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata,
  output logic                    bad_write,
  input  logic [NUM_LINES-1:0]    irq_in,
  input  logic [DW-1:0]           res_status,
  input  logic [DW-1:0]           res_vec_addr,
  output logic [NUM_LINES*DW-1:0] cfg_words,
  output logic [NUM_LINES-1:0]    en_mask,
  output logic [NUM_LINES-1:0]    pend_mask,
  output logic [DW-1:0]           ctl_cfg,
  output logic [DW-1:0]           vec_base
);
  localparam int unsigned LW   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int unsigned BASE = NUM_LINES;

  wr_strb_t strb;
  logic [NUM_LINES-1:0] sw_q, raw_q, mask_wd;
  logic [DW-1:0] stat_q, vaddr_q, cfg_rd, rd_mux;

  assign mask_wd = wdata[NUM_LINES-1:0];

  irq_csr_dec #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .wr_en(wr_en), .strb(strb)
  );

  irq_csr_cfg #(.NUM_LINES(NUM_LINES), .DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .we(strb.cfg), .widx(addr[LW-1:0]), .wdata(wdata),
    .ridx(addr[LW-1:0]), .rword(cfg_rd), .flat(cfg_words)
  );

  irq_csr_mask #(.W(NUM_LINES)) u_en (
    .clk(clk), .rst(rst), .wr(strb.en_wr), .set(strb.en_set), .clr(strb.en_clr),
    .wdata(mask_wd), .q(en_mask)
  );

  irq_csr_mask #(.W(NUM_LINES)) u_sw (
    .clk(clk), .rst(rst), .wr(strb.sw_wr), .set(strb.sw_set), .clr(strb.sw_clr),
    .wdata(mask_wd), .q(sw_q)
  );

  // Sampled inputs and word registers
  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q    <= '0;
      stat_q   <= '0;
      vaddr_q  <= '0;
      ctl_cfg  <= '0;
      vec_base <= '0;
    end else begin
      raw_q   <= irq_in;
      stat_q  <= res_status;
      vaddr_q <= res_vec_addr;
      if (strb.ctl_wr)  ctl_cfg  <= wdata;
      if (strb.base_wr) vec_base <= wdata;
    end
  end

  assign pend_mask = (raw_q | sw_q) & en_mask;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(BASE + ofs);
  endfunction

  always_comb begin
    rd_mux = '0;
    if (addr < ADDR_W'(NUM_LINES))  rd_mux = cfg_rd;
    else if (at(addr, OFS_EN))      rd_mux = DW'(en_mask);
    else if (at(addr, OFS_PEND))    rd_mux = DW'(pend_mask);
    else if (at(addr, OFS_RAW))     rd_mux = DW'(raw_q);
    else if (at(addr, OFS_SW))      rd_mux = DW'(sw_q);
    else if (at(addr, OFS_CTL))     rd_mux = ctl_cfg;
    else if (at(addr, OFS_STAT))    rd_mux = stat_q;
    else if (at(addr, OFS_BASE))    rd_mux = vec_base;
    else if (at(addr, OFS_VADDR))   rd_mux = vaddr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      bad_write <= 1'b0;
    end else begin
      bad_write <= strb.bad;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_csr_chk.sv
module irq_csr_chk #(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned ADDR_W    = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic [ADDR_W-1:0]       addr,
  input logic                    wr_en,
  input logic [DW-1:0]           wdata,
  input logic                    bad_write,
  input logic [NUM_LINES*DW-1:0] cfg_words,
  input logic [NUM_LINES-1:0]    en_mask,
  input logic [NUM_LINES-1:0]    pend_mask,
  input logic [DW-1:0]           ctl_cfg,
  input logic [DW-1:0]           vec_base
);
  localparam int unsigned LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(NUM_LINES);
  localparam logic [ADDR_W-1:0] A_ESET  = ADDR_W'(NUM_LINES + 1);
  localparam logic [ADDR_W-1:0] A_ECLR  = ADDR_W'(NUM_LINES + 2);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(NUM_LINES + 3);
  localparam logic [ADDR_W-1:0] A_CTL   = ADDR_W'(NUM_LINES + 8);

  logic          l_cfg;
  logic [LW-1:0] l_idx;
  logic [DW-1:0] l_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      l_cfg  <= 1'b0;
      l_idx  <= '0;
      l_data <= '0;
    end else begin
      l_cfg  <= wr_en && (addr < ADDR_W'(NUM_LINES));
      l_idx  <= addr[LW-1:0];
      l_data <= wdata;
    end
  end

  AST_CFG_STORED: assert property (@(posedge clk) disable iff (rst)
    l_cfg |-> cfg_words[l_idx*DW +: DW] == l_data); // R1

  AST_EN_DIRECT: assert property (@(posedge clk) disable iff (rst)
    wr_en && addr == A_EN |=> en_mask == $past(wdata[NUM_LINES-1:0])); // R2

  AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
    wr_en && addr == A_ESET |=>
      en_mask == ($past(en_mask) | $past(wdata[NUM_LINES-1:0]))); // R2

  AST_EN_CLR: assert property (@(posedge clk) disable iff (rst)
    wr_en && addr == A_ECLR |=>
      en_mask == ($past(en_mask) & ~$past(wdata[NUM_LINES-1:0]))); // R2

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(en_mask)); // R2

  AST_PEND_GATED: assert property (@(posedge clk) disable iff (rst)
    (pend_mask & ~en_mask) == '0); // R4

  AST_RO_FLAG: assert property (@(posedge clk) disable iff (rst)
    wr_en && addr == A_PEND |=> bad_write && $stable(en_mask)); // R9

  AST_CTL_GOOD: assert property (@(posedge clk) disable iff (rst)
    wr_en && addr == A_CTL |=> !bad_write && ctl_cfg == $past(wdata)); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> en_mask == '0 && pend_mask == '0 && ctl_cfg == '0 &&
            vec_base == '0 && !bad_write && cfg_words == '0); // R10
endmodule

bind irq_csr_bank irq_csr_chk #(.NUM_LINES(NUM_LINES), .DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .bad_write(bad_write), .cfg_words(cfg_words), .en_mask(en_mask),
  .pend_mask(pend_mask), .ctl_cfg(ctl_cfg), .vec_base(vec_base)
);

// File: tb/tb_irq_csr_bank.sv
`timescale 1ns/1ps
module tb_irq_csr_bank;
  localparam int NL = 32;
  localparam int DW = 32;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic bad_write;
  logic [NL-1:0] irq_in = '0;
  logic [DW-1:0] res_status = '0, res_vec_addr = '0;
  logic [NL*DW-1:0] cfg_words;
  logic [NL-1:0] en_mask, pend_mask;
  logic [DW-1:0] ctl_cfg, vec_base;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  irq_csr_bank #(.NUM_LINES(NL), .DW(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .bad_write(bad_write), .irq_in(irq_in),
    .res_status(res_status), .res_vec_addr(res_vec_addr), .cfg_words(cfg_words),
    .en_mask(en_mask), .pend_mask(pend_mask), .ctl_cfg(ctl_cfg), .vec_base(vec_base)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input int idx, input logic [DW-1:0] v, output logic b);
    addr = AW'(idx); wdata = v; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
    b = bad_write;
  endtask

  task automatic rd(input int idx, output logic [DW-1:0] v);
    addr = AW'(idx); rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R10 rdata", rdata, '0);
    chk("R10 bad_write", DW'(bad_write), '0);
    chk("R10 cfg export", DW'(cfg_words != '0), '0);
    foreach (v[i]) ; // keep v declared use simple
    for (int i = 32; i <= 43; i++) begin
      rd(i, v);
      chk($sformatf("R10 index %0d", i), v, '0);
    end
    rd(7, v);
    chk("R10 cfg word", v, '0);
  endtask

  task automatic t_cfg();
    logic [DW-1:0] v; logic b;
    wr(0, 32'h0000_1F3F, b);  chk("R1 bad low", DW'(b), '0);
    wr(17, 32'hDEAD_BEEF, b);
    wr(31, 32'h8000_0001, b);
    rd(0, v);  chk("R1 word0", v, 32'h0000_1F3F);
    rd(17, v); chk("R1 word17", v, 32'hDEAD_BEEF);
    rd(31, v); chk("R1 word31", v, 32'h8000_0001);
    chk("R1 export17", cfg_words[17*DW +: DW], 32'hDEAD_BEEF);
    chk("R1 export31", cfg_words[31*DW +: DW], 32'h8000_0001);
    chk("R1 export16 untouched", cfg_words[16*DW +: DW], '0);
  endtask

  task automatic t_enable();
    logic [DW-1:0] v; logic b;
    wr(32, 32'h0000_00F0, b); chk("R2 direct", DW'(en_mask), 32'h0000_00F0);
    wr(33, 32'h8000_000F, b); chk("R2 set", DW'(en_mask), 32'h8000_00FF);
    wr(34, 32'h0000_0030, b); chk("R2 clear", DW'(en_mask), 32'h8000_00CF);
    rd(32, v);                chk("R2 readback", v, 32'h8000_00CF);
    wr(32, 32'h0000_0000, b); chk("R2 direct zero", DW'(en_mask), '0);
  endtask

  task automatic t_sw_pend();
    logic [DW-1:0] v; logic b;
    wr(37, 32'h0000_0003, b);
    wr(38, 32'h0001_0000, b);
    wr(39, 32'h0000_0001, b);
    rd(37, v); chk("R3 sw mask", v, 32'h0001_0002);
    rd(35, v); chk("R4 pending all disabled", v, '0);
    wr(32, 32'h0001_0102, b);
    irq_in = 32'h0000_0300;
    tick();
    chk("R4 pend export", DW'(pend_mask), 32'h0001_0102);
    rd(35, v); chk("R4 pend read", v, 32'h0001_0102);
    wr(35, 32'hFFFF_FFFF, b); chk("R9 pend write flagged", DW'(b), 32'h1);
    tick(); chk("R9 flag one cycle", DW'(bad_write), '0);
    rd(35, v); chk("R9 pend unchanged", v, 32'h0001_0102);
  endtask

  task automatic t_raw();
    logic [DW-1:0] v; logic b;
    irq_in = 32'hA500_0005;
    tick();
    rd(36, v); chk("R5 raw high", v, 32'hA500_0005);
    irq_in = 32'h0000_0004;
    tick();
    rd(36, v); chk("R5 raw not latched", v, 32'h0000_0004);
    wr(36, 32'hFFFF_FFFF, b); chk("R9 raw write flagged", DW'(b), 32'h1);
    rd(36, v); chk("R9 raw unchanged", v, 32'h0000_0004);
    irq_in = '0;
  endtask

  task automatic t_ctl_base();
    logic [DW-1:0] v; logic b;
    wr(40, 32'h0000_0005, b); chk("R6 ctl write ok", DW'(b), '0);
    wr(42, 32'h1234_5600, b);
    rd(40, v); chk("R6 ctl read", v, 32'h0000_0005);
    rd(42, v); chk("R6 base read", v, 32'h1234_5600);
    chk("R6 ctl export", ctl_cfg, 32'h0000_0005);
    chk("R6 base export", vec_base, 32'h1234_5600);
  endtask

  task automatic t_resolver();
    logic [DW-1:0] v; logic b;
    res_status = 32'h8000_0011; res_vec_addr = 32'h1234_5780;
    tick();
    rd(41, v); chk("R7 status", v, 32'h8000_0011);
    rd(43, v); chk("R7 vec addr", v, 32'h1234_5780);
    wr(41, 32'h0, b); chk("R9 status write flagged", DW'(b), 32'h1);
    wr(43, 32'h0, b); chk("R9 vaddr write flagged", DW'(b), 32'h1);
    rd(41, v); chk("R9 status kept", v, 32'h8000_0011);
  endtask

  task automatic t_alias_unmapped();
    logic [DW-1:0] v; logic b;
    rd(33, v); chk("R8 en-set alias", v, '0);
    rd(34, v); chk("R8 en-clr alias", v, '0);
    rd(38, v); chk("R8 sw-set alias", v, '0);
    rd(39, v); chk("R8 sw-clr alias", v, '0);
    rd(50, v); chk("R8 unmapped read", v, '0);
    wr(44, 32'hFFFF_FFFF, b); chk("R9 unmapped 44 flagged", DW'(b), 32'h1);
    wr(63, 32'hFFFF_FFFF, b); chk("R9 unmapped 63 flagged", DW'(b), 32'h1);
    chk("R9 ctl unchanged", ctl_cfg, 32'h0000_0005);
    chk("R9 base unchanged", vec_base, 32'h1234_5600);
    chk("R9 enable unchanged", DW'(en_mask), 32'h0001_0102);
    chk("R9 word0 unchanged", cfg_words[0 +: DW], 32'h0000_1F3F);
  endtask

  task automatic t_hold();
    logic [DW-1:0] v; logic b;
    rd(42, v);
    wr(42, 32'h0BAD_0000, b);
    tick();
    chk("R11 rdata held", rdata, 32'h1234_5600);
    rd(42, v); chk("R11 new read", v, 32'h0BAD_0000);
  endtask

  task automatic t_reset_again();
    logic [DW-1:0] v;
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R10 re-reset rdata", rdata, '0);
    chk("R10 re-reset enable", DW'(en_mask), '0);
    chk("R10 re-reset cfg", DW'(cfg_words != '0), '0);
    rd(37, v); chk("R10 re-reset sw", v, '0);
    rd(41, v); chk("R10 re-reset status", v, 32'h8000_0011);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_cfg();
    t_enable();
    t_sw_pend();
    t_raw();
    t_ctl_base();
    t_resolver();
    t_alias_unmapped();
    t_hold();
    t_reset_again();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule